// File: doc/BRIEF.md
# Burst Serial Port with Byte Queue

This block is a synchronous serial port with an 8-bit shift path and an 8-entry byte queue. The host fills the queue through a valid/ready write stream, picks a burst length of 1 to 8 bytes and pulses `start`. The port then moves the whole burst without further help. Each byte goes out MSB first from the head of the queue. The byte received in its place is written back into the same slot. When the burst ends, the queue holds exactly the received bytes, and the host drains them through a valid/ready read stream.

The shift clock is either generated internally from the system clock or taken from the `sck_i` pin. In internal mode the port is the clock master and drives `sck_o`. In external mode the port is a slave. Outgoing data changes on the falling edge of the shift clock and incoming data is sampled on the rising edge. An optional select mode ties the port to an active-low select input. While the select is high, the clock and data output enables are off and the burst is held. If the select rises in the middle of a byte, the burst is aborted and an error flag is set.

Both host streams stall while a burst runs. On the write side, `in_ready` is low while busy, while `start` is high, or when the queue is full. On the read side, `out_valid` is low while busy, while `start` is high, or when the queue is empty. A byte moves only in a cycle where valid and ready are both high. The host holds valid and its data until that cycle.

Top module: `burst_serial_port`

## Requirements
- R1: A byte is stored when `in_valid && in_ready`. `in_ready` is high only when the port is idle, `start` is low and fewer than 8 bytes are queued. `out_valid` is high only when the port is idle, `start` is low and at least one byte is queued. `out_data` shows the oldest byte, and the queue pops when `out_valid && out_ready`. Bytes leave in the order they arrived.
- R2: When idle, a `start` pulse with `burst_len_m1 = L` (0..7) begins a burst of L+1 bytes taken from the head of the queue. A `start` while busy is ignored.
- R3: Each byte is sent MSB first. `sdo` changes only on a falling edge of the shift clock. `sdi` is sampled on the rising edge, and each received byte is assembled MSB first.
- R4: With `ext_clk_mode = 0`, `sck_o` is high when idle. It first falls one system clock after the `start` edge, and each period is 8 cycles low followed by 8 cycles high. Bytes follow each other with no gap.
- R5: With `ext_clk_mode = 1`, `sck_oe` is 0 and the burst advances only on edges of `sck_i`. Both `sck_i` and `sdi` pass through a two-flop synchronizer before use.
- R6: `busy` rises on the `start` edge. On the rising shift-clock edge that completes the last byte, `busy` falls and `done` is high for exactly one cycle. `done_flag` then stays high until the next start.
- R7: After a completed burst of L+1 bytes, the queue holds exactly those L+1 received bytes, oldest first.
- R8: With `cs_mode = 0`, `sdo_oe` is 1. With `cs_mode = 1`, `sdo_oe` and `sck_oe` are 0 while the synchronized `cs_n` is high. They turn on after `cs_n` falls, and `sck_oe` turns on only in internal-clock mode.
- R9: With `cs_mode = 1`, if the synchronized `cs_n` rises after a byte has had at least one falling edge but before it completes, the burst aborts. `busy` falls, `abort_err` is set, and `done` does not pulse. Bytes already completed stay in their slots, the queue count is unchanged, and the next start clears `abort_err`.
- R10: With `cs_mode = 1`, a burst started while `cs_n` is high does not clock until `cs_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Write stream valid |
| in_ready | output | 1 | Write stream ready |
| in_data | input | 8 | Byte to queue |
| out_valid | output | 1 | Read stream valid |
| out_ready | input | 1 | Read stream ready |
| out_data | output | 8 | Oldest queued byte |
| start | input | 1 | Burst start pulse |
| burst_len_m1 | input | 3 | Burst length minus one |
| ext_clk_mode | input | 1 | 1: shift clock from sck_i |
| cs_mode | input | 1 | 1: transfer gated by cs_n |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| done_flag | output | 1 | Sticky burst-complete flag |
| abort_err | output | 1 | Sticky select-abort flag |
| sck_i | input | 1 | External shift clock |
| sck_o | output | 1 | Internal shift clock |
| sck_oe | output | 1 | Shift clock output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| cs_n | input | 1 | Active-low select |

## Verification
Some properties are checked on every cycle. In internal-clock mode, `sdo` changes only together with a falling `sck_o`. The clock rests high once the port has been idle for a cycle. `done` never coincides with `busy`, and an abort never comes with a done pulse. The queue is never pushed when full or popped when empty. The bench shows what only whole scenarios can. It sweeps all eight burst lengths in both clock modes with a modelled far-end device, checks the exact 8/8 phase timing and the first-edge latency, and confirms that a mid-burst start is ignored. It also covers select gating, the stall while the select is high, and an abort that keeps the completed byte.

// File: rtl/bsp_pkg.sv
`timescale 1ns/1ps
package bsp_pkg;
  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} clk_src_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } sck_edge_t;
endpackage

// File: rtl/bsp_sync.sv
`timescale 1ns/1ps
module bsp_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '1
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= INIT;
      s2_q <= INIT;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/bsp_clkgen.sv
`timescale 1ns/1ps
module bsp_clkgen import bsp_pkg::*; #(
  parameter int HALF = 8
)(
  input  logic      clk,
  input  logic      rst_n,
  input  clk_src_e  src,
  input  logic      run,
  input  logic      idle,
  input  logic      sck_ext_s,
  output sck_edge_t ev,
  output logic      sck_int
);
  localparam int PER = 2 * HALF;
  localparam int DVW = $clog2(PER);
  localparam logic [DVW-1:0] HALF_V = DVW'(HALF);
  localparam logic [DVW-1:0] LAST_V = DVW'(PER - 1);

  logic [DVW-1:0] div_q;
  logic           sck_q;
  logic           ext_prev_q;

  always_comb begin
    if (src == SRC_EXT) begin
      ev.fall = run && ext_prev_q && !sck_ext_s;
      ev.rise = run && !ext_prev_q && sck_ext_s;
    end else begin
      ev.fall = run && (div_q == '0);
      ev.rise = run && (div_q == HALF_V);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q      <= '0;
      sck_q      <= 1'b1;
      ext_prev_q <= 1'b1;
    end else begin
      ext_prev_q <= sck_ext_s;
      if (idle) begin
        div_q <= '0;
        sck_q <= 1'b1;
      end else if (run && src == SRC_INT) begin
        div_q <= (div_q == LAST_V) ? '0 : div_q + 1'b1;
        if (div_q == '0)         sck_q <= 1'b0;
        else if (div_q == HALF_V) sck_q <= 1'b1;
      end
    end
  end

  assign sck_int = sck_q;

  // R4: an internal falling event is always followed by a low clock
  a_r4_fall_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_INT && ev.fall) |=> !sck_int);
  // R4: an internal rising event is always followed by a high clock
  a_r4_rise_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_INT && ev.rise) |=> sck_int);
endmodule

// File: rtl/bsp_fifo.sv
`timescale 1ns/1ps
module bsp_fifo #(
  parameter int DEPTH = 8,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic [DW-1:0] push_data,
  input  logic          pop_en,
  input  logic          xw_en,
  input  logic [AW-1:0] xw_off,
  input  logic [DW-1:0] xw_data,
  input  logic [AW-1:0] xr_off,
  input  logic          set_cnt_en,
  input  logic [CW-1:0] set_cnt_val,
  output logic [DW-1:0] head_data,
  output logic [DW-1:0] xr_data,
  output logic [CW-1:0] cnt
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] head_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] tail_a, xw_a, xr_a;

  assign tail_a = head_q + cnt_q[AW-1:0];
  assign xw_a   = head_q + xw_off;
  assign xr_a   = head_q + xr_off;

  always_ff @(posedge clk) begin
    if (push_en) mem_q[tail_a] <= push_data;
    if (xw_en)   mem_q[xw_a]   <= xw_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop_en) head_q <= head_q + 1'b1;
      if (set_cnt_en) cnt_q <= set_cnt_val;
      else            cnt_q <= cnt_q + CW'(push_en) - CW'(pop_en);
    end
  end

  assign head_data = mem_q[head_q];
  assign xr_data   = mem_q[xr_a];
  assign cnt       = cnt_q;

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> (cnt_q < CW'(DEPTH)));
  a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> (cnt_q != '0));
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/burst_serial_port.sv
`timescale 1ns/1ps
module burst_serial_port import bsp_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int DW = 8,
  parameter int HALF = 8,
  localparam int AW = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  input  logic          start,
  input  logic [AW-1:0] burst_len_m1,
  input  logic          ext_clk_mode,
  input  logic          cs_mode,
  output logic          busy,
  output logic          done,
  output logic          done_flag,
  output logic          abort_err,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic          cs_n
);
  localparam int CW  = AW + 1;
  localparam int BCW = $clog2(DW);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

  // synchronized pins: {sck, select, data}
  logic [2:0] pins_s;
  logic       sck_s, cs_s, sdi_s;
  bsp_sync #(.W(3), .INIT(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck_i, cs_n, sdi}), .q(pins_s));
  assign {sck_s, cs_s, sdi_s} = pins_s;

  logic          busy_q, done_q, done_flag_q, err_q, mid_q, cs_d_q, sdo_q;
  logic [AW-1:0] len_q, idx_q;
  logic [BCW-1:0] bitn_q;
  logic [DW-1:0] sh_tx_q, sh_rx_q;

  clk_src_e  src;
  sck_edge_t ev;
  logic      active, run, sdi_x, cs_rise, abort, byte_end, burst_end, start_ok;
  logic      push_en, pop_en;
  logic [DW-1:0] head_data, xr_data, rx_byte;
  logic [CW-1:0] cnt;

  assign src      = ext_clk_mode ? SRC_EXT : SRC_INT;
  assign active   = !cs_mode || !cs_s;
  assign run      = busy_q && active;
  assign sdi_x    = ext_clk_mode ? sdi_s : sdi;
  assign cs_rise  = cs_s && !cs_d_q;
  assign abort    = busy_q && cs_mode && cs_rise && mid_q;
  assign byte_end = ev.rise && (bitn_q == LAST_BIT);
  assign burst_end = byte_end && (idx_q == len_q);
  assign start_ok = start && !busy_q;
  assign rx_byte  = {sh_rx_q[DW-2:0], sdi_x};

  bsp_clkgen #(.HALF(HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .src(src), .run(run), .idle(!busy_q),
    .sck_ext_s(sck_s), .ev(ev), .sck_int(sck_o));

  assign in_ready  = !busy_q && !start && (cnt < CW'(DEPTH));
  assign out_valid = !busy_q && !start && (cnt != '0);
  assign push_en   = in_valid && in_ready;
  assign pop_en    = out_valid && out_ready;

  bsp_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_en(push_en), .push_data(in_data), .pop_en(pop_en),
    .xw_en(byte_end), .xw_off(idx_q), .xw_data(rx_byte),
    .xr_off(busy_q ? idx_q + 1'b1 : '0),
    .set_cnt_en(burst_end), .set_cnt_val(CW'(len_q) + CW'(1)),
    .head_data(out_data), .xr_data(xr_data), .cnt(cnt));
  assign head_data = out_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      done_flag_q <= 1'b0;
      err_q       <= 1'b0;
      mid_q       <= 1'b0;
      cs_d_q      <= 1'b1;
      sdo_q       <= 1'b1;
      len_q       <= '0;
      idx_q       <= '0;
      bitn_q      <= '0;
      sh_tx_q     <= '0;
      sh_rx_q     <= '0;
    end else begin
      cs_d_q <= cs_s;
      done_q <= burst_end;
      if (start_ok) begin
        busy_q      <= 1'b1;
        len_q       <= burst_len_m1;
        idx_q       <= '0;
        bitn_q      <= '0;
        mid_q       <= 1'b0;
        sh_tx_q     <= xr_data;
        done_flag_q <= 1'b0;
        err_q       <= 1'b0;
      end else if (abort) begin
        busy_q <= 1'b0;
        err_q  <= 1'b1;
        mid_q  <= 1'b0;
      end else begin
        if (ev.fall) begin
          sdo_q   <= sh_tx_q[DW-1];
          sh_tx_q <= {sh_tx_q[DW-2:0], 1'b0};
          mid_q   <= 1'b1;
        end
        if (ev.rise) begin
          sh_rx_q <= rx_byte;
          bitn_q  <= bitn_q + 1'b1;
          if (byte_end) begin
            mid_q <= 1'b0;
            if (burst_end) begin
              busy_q      <= 1'b0;
              done_flag_q <= 1'b1;
            end else begin
              idx_q   <= idx_q + 1'b1;
              sh_tx_q <= xr_data;
            end
          end
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign done_flag = done_flag_q;
  assign abort_err = err_q;
  assign sdo       = sdo_q;
  assign sdo_oe    = active;
  assign sck_oe    = active && !ext_clk_mode;

  // R6: the completion pulse never overlaps a running burst
  a_r6_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && done_flag));
  // R9: an abort never comes with a completion pulse
  a_r9_abort_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_err) |-> (!done && !busy));
  // R3: internal clock, data moves only with a falling shift clock
  a_r3_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_clk_mode && $past(!ext_clk_mode) && !$stable(sdo)) |-> $fell(sck_o));
  // R4: clock rests high once idle for a cycle
  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> sck_o);
  // R8: no clock drive while data drive is off
  a_r8_oe_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sck_oe);
  // R2: a start while busy leaves the burst running
  a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done_flag && !abort_err) |=> (busy || done_flag || abort_err));
endmodule

// File: tb/tb_burst_serial_port.sv
`timescale 1ns/1ps
module tb_burst_serial_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, start = 1'b0;
  logic [7:0] in_data = '0;
  logic [2:0] burst_len_m1 = '0;
  logic ext_clk_mode = 1'b0, cs_mode = 1'b0;
  logic sck_i = 1'b1, sdi = 1'b0, cs_n = 1'b1;
  logic in_ready, out_valid, busy, done, done_flag, abort_err;
  logic sck_o, sck_oe, sdo, sdo_oe;
  logic [7:0] out_data;

  int errors = 0;
  int checks = 0;
  logic [7:0] tx_b [8];
  logic [7:0] rx_b [8];

  always #10 clk = ~clk;

  burst_serial_port dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .start(start), .burst_len_m1(burst_len_m1),
    .ext_clk_mode(ext_clk_mode), .cs_mode(cs_mode),
    .busy(busy), .done(done), .done_flag(done_flag), .abort_err(abort_err),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .cs_n(cs_n));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  task automatic push_byte(input logic [7:0] b);
    int t = 0;
    while (!in_ready && t < 64) begin @(negedge clk); t++; end
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_byte(output logic [7:0] b);
    int t = 0;
    while (!out_valid && t < 64) begin @(negedge clk); t++; end
    b = out_data; out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic start_burst(input int len);
    burst_len_m1 = 3'(len - 1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_sck(input logic lvl, output int n);
    n = 0;
    while (sck_o !== lvl && n < 64) begin @(negedge clk); n++; end
  endtask

  task automatic fill(input int len, input int seed);
    for (int k = 0; k < len; k++) begin
      tx_b[k] = 8'(seed * 37 + k * 29 + 5);
      rx_b[k] = 8'(seed * 11 + k * 53 + 60);
      push_byte(tx_b[k]);
    end
  endtask

  // far-end device on the internal clock: new bit at each fall, sdo read after each rise
  task automatic serve(input int first, input int nbits, input bit timing,
                       inout int bit_err, inout int tim_err);
    int n;
    for (int j = first; j < first + nbits; j++) begin
      wait_sck(1'b0, n);
      if (timing && j == 0 && n != 1) tim_err++;
      if (timing && j > 0 && n != 8) tim_err++;
      if (n >= 64) tim_err++;
      sdi = rx_b[j / 8][7 - (j % 8)];
      wait_sck(1'b1, n);
      if (timing && n != 8) tim_err++;
      if (n >= 64) tim_err++;
      if (sdo !== tx_b[j / 8][7 - (j % 8)]) bit_err++;
    end
  endtask

  task automatic drain_check(input int len, input string req);
    logic [7:0] b;
    int bad = 0;
    for (int k = 0; k < len; k++) begin
      pop_byte(b);
      if (b !== rx_b[k]) bad++;
    end
    chk({req, " received bytes mismatched"}, bad, 0);
    chk({req, " queue empty after drain"}, int'(out_valid), 0);
  endtask

  task automatic run_int(input int len, input int seed);
    int be = 0, te = 0;
    fill(len, seed);
    start_burst(len);
    chk("R6 busy after start", int'(busy), 1);
    if (len == 3) begin
      serve(0, 4, 1'b1, be, te);
      burst_len_m1 = 3'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      serve(4, 20, 1'b0, be, te);
      chk("R2 start during burst ignored", be + te, 0);
    end else begin
      serve(0, 8 * len, 1'b1, be, te);
    end
    chk("R3 sdo bits msb first", be, 0);
    chk("R4 internal clock timing", te, 0);
    chk("R6 done pulse at last rise", int'(done), 1);
    chk("R6 busy low at end", int'(busy), 0);
    @(negedge clk);
    chk("R6 done one cycle", int'(done), 0);
    chk("R6 done_flag sticky", int'(done_flag), 1);
    drain_check(len, "R7");
  endtask

  task automatic run_ext(input int len, input int seed);
    int be = 0;
    ext_clk_mode = 1'b1;
    fill(len, seed);
    start_burst(len);
    repeat (20) @(negedge clk);
    chk("R5 no progress without sck_i", int'(busy), 1);
    chk("R5 sck_oe off", int'(sck_oe), 0);
    for (int j = 0; j < 8 * len; j++) begin
      sck_i = 1'b0; sdi = rx_b[j / 8][7 - (j % 8)];
      repeat (6) @(negedge clk);
      if (sdo !== tx_b[j / 8][7 - (j % 8)]) be++;
      sck_i = 1'b1;
      repeat (6) @(negedge clk);
    end
    chk("R5 R3 external sdo bits", be, 0);
    chk("R5 burst ends on external clock", int'(busy), 0);
    chk("R6 done_flag external", int'(done_flag), 1);
    drain_check(len, "R7 external");
    ext_clk_mode = 1'b0;
  endtask

  task automatic run_cs();
    int be = 0, te = 0, n;
    logic [7:0] b;
    cs_mode = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 sdo_oe off while select high", int'(sdo_oe), 0);
    chk("R8 sck_oe off while select high", int'(sck_oe), 0);
    fill(2, 70);
    start_burst(2);
    repeat (40) @(negedge clk);
    chk("R10 no clock while select high", int'(sck_o), 1);
    chk("R10 burst pending", int'(busy), 1);
    chk("R1 no write while busy", int'(in_ready), 0);
    chk("R1 no read while busy", int'(out_valid), 0);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 sdo_oe on after select low", int'(sdo_oe), 1);
    chk("R8 sck_oe on after select low", int'(sck_oe), 1);
    serve(0, 16, 1'b0, be, te);
    chk("R10 R3 select burst bits", be + te, 0);
    chk("R6 done in select mode", int'(done), 1);
    drain_check(2, "R7 select");
    // abort in the middle of the second byte
    be = 0; te = 0;
    fill(3, 80);
    start_burst(3);
    serve(0, 12, 1'b0, be, te);
    wait_sck(1'b0, n);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 busy cleared by abort", int'(busy), 0);
    chk("R9 abort_err set", int'(abort_err), 1);
    chk("R9 no done_flag on abort", int'(done_flag), 0);
    chk("R8 sdo_oe off after select rise", int'(sdo_oe), 0);
    pop_byte(b);
    chk("R9 completed byte kept", int'(b), int'(rx_b[0]));
    pop_byte(b);
    pop_byte(b);
    chk("R9 count unchanged by abort", int'(out_valid), 0);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    be = 0; te = 0;
    fill(1, 90);
    start_burst(1);
    chk("R9 abort_err cleared by start", int'(abort_err), 0);
    serve(0, 8, 1'b0, be, te);
    chk("R9 burst after abort", be + te, 0);
    drain_check(1, "R7 after abort");
    cs_n = 1'b1;
    cs_mode = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] b;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset in_ready", int'(in_ready), 1);
    chk("R1 reset out_valid", int'(out_valid), 0);
    chk("R6 reset busy", int'(busy), 0);
    chk("R6 reset done_flag", int'(done_flag), 0);
    chk("R4 reset sck_o high", int'(sck_o), 1);
    chk("R8 reset sdo_oe in plain mode", int'(sdo_oe), 1);
    chk("R4 sck_oe in internal mode", int'(sck_oe), 1);
    chk("R9 reset abort_err", int'(abort_err), 0);
    repeat (30) @(negedge clk);
    chk("R4 no clock when idle", int'(sck_o), 1);
    // queue order and full limit
    for (int k = 0; k < 8; k++) push_byte(8'(k * 19 + 3));
    chk("R1 full blocks writes", int'(in_ready), 0);
    bad = 0;
    for (int k = 0; k < 8; k++) begin
      pop_byte(b);
      if (b !== 8'(k * 19 + 3)) bad++;
    end
    chk("R1 bytes leave in order", bad, 0);
    chk("R1 empty after pops", int'(out_valid), 0);
    for (int len = 1; len <= 8; len++) run_int(len, len);
    for (int len = 1; len <= 8; len++) run_int(len, len + 20);
    for (int len = 1; len <= 8; len++) run_ext(len, len + 40);
    run_cs();
    summary();
  end
endmodule